// File: doc/BRIEF.md
# Line-State and Timed Flash Controller

This block keeps track of the telephone line condition for a dialer chip. It watches a debounced hook-switch level, a low-going handsfree pulse input and a hold-key strobe, and from these it decides whether the chip is enabled and whether the handsfree drive is on. It also produces timed flash breaks: a flash-key strobe with a 2-bit selector starts a break of one of four lengths, followed by a fixed pause, after which a one-cycle "return to initial state" pulse tells the rest of the dialer to clear store mode and start fresh.

All timing runs off a 1 ms tick input, so break, pause and debounce lengths are parameters in milliseconds. A key-acceptance output tells the keypad logic whether an ordinary key strobe may be taken: it is refused while the chip is disabled, while on hold, while a flash is in progress, and when a flash key arrives in the same cycle.

The line state machine has four states. `LN_OFF` is the on-hook, disabled state (reset state). `LN_TALK` is off-hook normal operation. `LN_HANDS` is handsfree active. `LN_HOLD` is hold active. Its transitions are: a settled off-hook edge sends any state to `LN_TALK`. A handsfree pulse takes `LN_OFF` or `LN_TALK` to `LN_HANDS` and `LN_HOLD` to `LN_HANDS`. It takes `LN_HANDS` back to `LN_OFF` when on-hook or to `LN_TALK` when off-hook. A hold strobe takes `LN_TALK` or `LN_HANDS` to `LN_HOLD`, and takes `LN_HOLD` to `LN_OFF` or `LN_TALK` by hook level. A settled on-hook edge takes `LN_TALK` to `LN_OFF`. A handsfree pulse wins over a hold strobe in the same cycle. The flash machine has three states. `FL_IDLE` goes to `FL_BREAK` on an accepted flash. `FL_BREAK` goes to `FL_PAUSE` after the selected length. `FL_PAUSE` goes back to `FL_IDLE` with the completion pulse. Any state returns to `FL_IDLE` on abort, which is an off-hook edge or the line entering `LN_OFF`.

Top module: `line_flash_ctl`

## Requirements
- R1: After reset, chip_en, hf_out, hp_mute, dp_flash, init_pulse and key_ok are all 0. chip_en is 1 exactly when the line is off-hook (settled) or handsfree or hold is active.
- R2: A change on hook_sw takes effect only after it has stayed at the new level for DEB_SLOW ticks when lock_mode is 0, or DEB_FAST ticks when lock_mode is 1, counting the tick at the edge where the new level is first sampled. hook_sw is 1 for on-hook.
- R3: A falling edge on hf_in_n toggles handsfree. If hold is active, the edge instead ends hold and leaves handsfree active (hf_out stays 1, hp_mute goes 0).
- R4: A hold_key strobe while enabled and not on hold enters hold, with hf_out and hp_mute both 1. A second strobe leaves hold, with hf_out 0.
- R5: hold_key has no effect while the chip is disabled: hf_out, hp_mute and chip_en stay 0.
- R6: A settled off-hook transition puts the line in normal talk state with hf_out 0 and hp_mute 0, whatever the previous state, and cancels any flash.
- R7: While on hold, key_ok stays 0 for every other_key strobe and flash_key is not accepted.
- R8: An accepted flash raises dp_flash and hp_mute on the next cycle and holds them for BRK_F1, BRK_F2, BRK_F3 or BRK_F4 ticks for flash_sel 0, 1, 2 or 3.
- R9: After the break, a pause of PAUSE_MS ticks follows. At its end, init_pulse is 1 for exactly one cycle.
- R10: A flash_key strobe during an active flash (break or pause) is ignored; the running break keeps its original length.
- R11: key_ok is 0 during a flash, and 0 when flash_key and other_key arrive in the same cycle; the flash is still accepted in that case.
- R12: Going on-hook during a flash in talk state disables the chip, drops dp_flash and gives no init_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| lock_mode | input | 1 | 1 selects the short hook debounce |
| hook_sw | input | 1 | Raw hook switch, 1 = on-hook |
| hf_in_n | input | 1 | Handsfree request, active on falling edge |
| hold_key | input | 1 | One-cycle hold key strobe |
| flash_key | input | 1 | One-cycle flash key strobe |
| flash_sel | input | 2 | Flash key number minus one |
| other_key | input | 1 | One-cycle strobe for any other key |
| chip_en | output | 1 | Chip enabled |
| hf_out | output | 1 | Handsfree drive |
| hp_mute | output | 1 | Mute during hold or flash break |
| dp_flash | output | 1 | Dial output driven by a flash break |
| init_pulse | output | 1 | Flash finished, return to initial state |
| key_ok | output | 1 | The other_key strobe of this cycle is accepted |

## Verification
The bench builds the block with flash breaks of 11, 7, 3 and 5 ticks, a 13-tick pause and debounce lengths of 8 and 3 ticks, with a tick every fourth clock. These short lengths let every break length, the pause, both debounce lengths and flashes cut short by on-hook all be measured tick-exactly in a few thousand cycles. The distinct values also make a break taken from the wrong selector entry show up as a count mismatch. Random handsfree, hold and key strobes at both hook levels then walk every line-state transition against a bench model.

// File: rtl/lc_pkg.sv
package lc_pkg;
    typedef enum logic [1:0] {
        LN_OFF   = 2'd0,
        LN_TALK  = 2'd1,
        LN_HANDS = 2'd2,
        LN_HOLD  = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_BREAK = 2'd1,
        FL_PAUSE = 2'd2
    } fl_st_t;
endpackage

// File: rtl/lc_debounce.sv
module lc_debounce #(
    parameter int DEB_SLOW = 150,
    parameter int DEB_FAST = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int DMAX = (DEB_SLOW > DEB_FAST) ? DEB_SLOW : DEB_FAST;
    localparam int DCW  = $clog2(DMAX + 1);
    localparam logic [DCW-1:0] SLOW_LAST = DCW'(DEB_SLOW - 1);
    localparam logic [DCW-1:0] FAST_LAST = DCW'(DEB_FAST - 1);

    logic [DCW-1:0] cnt;
    logic           settle;

    // the differing level has lasted its full window on this tick
    always_comb begin
        settle = (raw != level) && tick && (cnt == (fast ? FAST_LAST : SLOW_LAST));
        rise   = settle && raw;
        fall   = settle && !raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b1;
            cnt   <= '0;
        end else if (raw == level) begin
            cnt <= '0;
        end else if (settle) begin
            level <= raw;
            cnt   <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lc_flash.sv
module lc_flash #(
    parameter int BRK_F1   = 600,
    parameter int BRK_F2   = 300,
    parameter int BRK_F3   = 73,
    parameter int BRK_F4   = 100,
    parameter int PAUSE_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic [1:0] sel,
    input  logic       abort,
    output logic       brk,
    output logic       idle,
    output logic       done
);
    import lc_pkg::*;

    localparam int NKEY = 4;
    localparam int BMAX01 = (BRK_F1 > BRK_F2) ? BRK_F1 : BRK_F2;
    localparam int BMAX23 = (BRK_F3 > BRK_F4) ? BRK_F3 : BRK_F4;
    localparam int BMAX   = (BMAX01 > BMAX23) ? BMAX01 : BMAX23;
    localparam int TMAX   = (BMAX > PAUSE_MS) ? BMAX : PAUSE_MS;
    localparam int CW     = $clog2(TMAX + 1);
    localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_MS - 1);

    logic [CW-1:0] len_tab [NKEY];
    logic [CW-1:0] len_last;
    logic [CW-1:0] cnt;
    fl_st_t        st;

    // last-tick index of each key's break, one entry per flash key
    for (genvar k = 0; k < NKEY; k++) begin : g_len
        localparam int LEN = (k == 0) ? BRK_F1 : (k == 1) ? BRK_F2 :
                             (k == 2) ? BRK_F3 : BRK_F4;
        assign len_tab[k] = CW'(LEN - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= FL_IDLE;
            cnt      <= '0;
            len_last <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                st  <= FL_IDLE;
                cnt <= '0;
            end else begin
                unique case (st)
                    FL_IDLE: if (go) begin
                        st       <= FL_BREAK;
                        len_last <= len_tab[sel];
                        cnt      <= '0;
                    end
                    FL_BREAK: if (tick) begin
                        if (cnt == len_last) begin
                            st  <= FL_PAUSE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FL_PAUSE: if (tick) begin
                        if (cnt == PAUSE_LAST) begin
                            st   <= FL_IDLE;
                            cnt  <= '0;
                            done <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= FL_IDLE;
                endcase
            end
        end
    end

    assign brk  = (st == FL_BREAK);
    assign idle = (st == FL_IDLE);
endmodule

// File: rtl/line_flash_ctl.sv
module line_flash_ctl #(
    parameter int BRK_F1   = 600,
    parameter int BRK_F2   = 300,
    parameter int BRK_F3   = 73,
    parameter int BRK_F4   = 100,
    parameter int PAUSE_MS = 1000,
    parameter int DEB_SLOW = 150,
    parameter int DEB_FAST = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       lock_mode,
    input  logic       hook_sw,
    input  logic       hf_in_n,
    input  logic       hold_key,
    input  logic       flash_key,
    input  logic [1:0] flash_sel,
    input  logic       other_key,
    output logic       chip_en,
    output logic       hf_out,
    output logic       hp_mute,
    output logic       dp_flash,
    output logic       init_pulse,
    output logic       key_ok
);
    import lc_pkg::*;

    logic     hook_db, hook_rise, hook_fall;
    logic     hf_prev, hf_ev, onhook;
    logic     fl_brk, fl_idle, fl_done, fl_go, fl_abort, keys_live;
    line_st_t st, st_nxt;

    lc_debounce #(.DEB_SLOW(DEB_SLOW), .DEB_FAST(DEB_FAST)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1ms),
        .fast  (lock_mode),
        .raw   (hook_sw),
        .level (hook_db),
        .rise  (hook_rise),
        .fall  (hook_fall)
    );

    lc_flash #(
        .BRK_F1(BRK_F1), .BRK_F2(BRK_F2), .BRK_F3(BRK_F3), .BRK_F4(BRK_F4),
        .PAUSE_MS(PAUSE_MS)
    ) u_flash (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1ms),
        .go    (fl_go),
        .sel   (flash_sel),
        .abort (fl_abort),
        .brk   (fl_brk),
        .idle  (fl_idle),
        .done  (fl_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hf_prev <= 1'b1;
        else        hf_prev <= hf_in_n;
    end

    assign hf_ev  = hf_prev && !hf_in_n;
    assign onhook = hook_db || hook_rise;

    // next line state
    always_comb begin
        st_nxt = st;
        if (hook_fall) begin
            st_nxt = LN_TALK;
        end else begin
            unique case (st)
                LN_OFF:   if (hf_ev) st_nxt = LN_HANDS;
                LN_TALK:  if (hf_ev)          st_nxt = LN_HANDS;
                          else if (hold_key)  st_nxt = LN_HOLD;
                          else if (hook_rise) st_nxt = LN_OFF;
                LN_HANDS: if (hf_ev)          st_nxt = onhook ? LN_OFF : LN_TALK;
                          else if (hold_key)  st_nxt = LN_HOLD;
                LN_HOLD:  if (hf_ev)          st_nxt = LN_HANDS;
                          else if (hold_key)  st_nxt = onhook ? LN_OFF : LN_TALK;
                default:  st_nxt = LN_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LN_OFF;
        else        st <= st_nxt;
    end

    // outputs and key gating
    always_comb begin
        keys_live  = (st == LN_TALK) || (st == LN_HANDS);
        fl_go      = flash_key && keys_live && fl_idle;
        fl_abort   = hook_fall || (st_nxt == LN_OFF);
        chip_en    = (st != LN_OFF);
        hf_out     = (st == LN_HANDS) || (st == LN_HOLD);
        hp_mute    = (st == LN_HOLD) || fl_brk;
        dp_flash   = fl_brk;
        init_pulse = fl_done;
        key_ok     = other_key && keys_live && fl_idle && !flash_key;
    end
endmodule

// File: rtl/lc_check.sv
module lc_check (
    input logic       clk,
    input logic       rst_n,
    input logic       hf_in_n,
    input logic       hold_key,
    input logic       flash_key,
    input logic       other_key,
    input logic       chip_en,
    input logic       hf_out,
    input logic       hp_mute,
    input logic       dp_flash,
    input logic       init_pulse,
    input logic       key_ok
);
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (!dp_flash && !key_ok && !hf_out && !hp_mute));

    p_hold_drives_hf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_mute && !dp_flash) |-> hf_out);

    p_hold_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && hold_key && hf_in_n) |=> !hp_mute);

    p_hold_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_mute && !dp_flash) |-> !key_ok);

    p_break_mutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_flash |-> hp_mute);

    p_init_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    p_init_not_in_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |-> !dp_flash);

    p_flash_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_key && other_key) |-> !key_ok);

    p_break_no_keys_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dp_flash |-> !key_ok);
endmodule

bind line_flash_ctl lc_check u_lc_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .hf_in_n    (hf_in_n),
    .hold_key   (hold_key),
    .flash_key  (flash_key),
    .other_key  (other_key),
    .chip_en    (chip_en),
    .hf_out     (hf_out),
    .hp_mute    (hp_mute),
    .dp_flash   (dp_flash),
    .init_pulse (init_pulse),
    .key_ok     (key_ok)
);

// File: tb/test_line_flash_ctl.sv
`timescale 1ns/1ps
module test_line_flash_ctl;
    localparam int B1 = 11, B2 = 7, B3 = 3, B4 = 5;
    localparam int PS = 13, DS = 8, DF = 3;
    localparam int M_OFF = 0, M_TALK = 1, M_HANDS = 2, M_HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0, lock_mode = 1'b0, hook_sw = 1'b1, hf_in_n = 1'b1;
    logic hold_key = 1'b0, flash_key = 1'b0, other_key = 1'b0;
    logic [1:0] flash_sel = 2'd0;
    logic chip_en, hf_out, hp_mute, dp_flash, init_pulse, key_ok;

    int total = 0, bad = 0, cyc = 0;
    int brk_n = 0, pse_n = 0, init_n = 0;
    bit in_fl = 0, fl_end = 0;

    always #2.5 clk = ~clk;

    line_flash_ctl #(
        .BRK_F1(B1), .BRK_F2(B2), .BRK_F3(B3), .BRK_F4(B4),
        .PAUSE_MS(PS), .DEB_SLOW(DS), .DEB_FAST(DF)
    ) i_line_flash_ctl (.*);

    function automatic int brk_len(input int s);
        return (s == 0) ? B1 : (s == 1) ? B2 : (s == 2) ? B3 : B4;
    endfunction

    function automatic int next_m(input int m, input bit hfe, input bit hk, input bit onh);
        if (hfe) begin
            if (m == M_HANDS) return onh ? M_OFF : M_TALK;
            return M_HANDS;
        end
        if (hk && m != M_OFF) begin
            if (m == M_HOLD) return onh ? M_OFF : M_TALK;
            return M_HOLD;
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // inputs set by the caller apply at the next rising edge
    task automatic step();
        tick_1ms = (cyc % 4 == 0);
        cyc++;
        if (in_fl && tick_1ms) begin
            if (dp_flash) brk_n++;
            else          pse_n++;
        end
        @(posedge clk);
        @(negedge clk);
        if (init_pulse) begin
            init_n++;
            if (in_fl) begin in_fl = 0; fl_end = 1; end
        end
        hold_key = 0; flash_key = 0; other_key = 0;
    endtask

    task automatic align();
        while (cyc % 4 == 0) step();
    endtask

    task automatic hf_pulse();
        hf_in_n = 0; step(); hf_in_n = 1; step();
    endtask

    // drive hook and count ticks until chip_en reaches target
    task automatic hook_to(input bit lvl, input bit en_target, input int exp, input string req);
        int n = 0;
        hook_sw = lvl;
        for (int i = 0; i < 400 && chip_en != en_target; i++) begin
            if (cyc % 4 == 0) n++;
            step();
        end
        chip_en_chk: chk(chip_en == en_target && n == exp, req, n, exp);
    endtask

    task automatic run_flash(input int s, input bit repress);
        align();
        flash_sel = 2'(s); flash_key = 1;
        brk_n = 0; pse_n = 0; init_n = 0; fl_end = 0;
        step();
        in_fl = 1;
        chk(dp_flash == 1 && hp_mute == 1, "R8 break starts", dp_flash, 1);
        other_key = 1; #1;
        chk(key_ok == 0, "R11 key refused in flash", key_ok, 0);
        step();
        if (repress) begin
            flash_sel = 2'(3 - s); flash_key = 1; step();
            step(); step();
            flash_sel = 2'(3 - s); flash_key = 1; step();
        end
        for (int i = 0; i < 1000 && !fl_end; i++) step();
        chk(brk_n == brk_len(s), repress ? "R10 repress ignored" : "R8 break length",
            brk_n, brk_len(s));
        chk(pse_n == PS, "R9 pause length", pse_n, PS);
        step();
        chk(init_n == 1 && init_pulse == 0, "R9 single init pulse", init_n, 1);
        flash_sel = 2'(3 - s); flash_key = 1; step();
        chk(dp_flash == 1, "R10 idle again accepts flash", dp_flash, 1);
        in_fl = 1; fl_end = 0;
        for (int i = 0; i < 1000 && !fl_end; i++) step();
        in_fl = 0;
    endtask

    initial begin
        int m;
        bit prev_hf, onh;
        void'($urandom(32'h5EED_0412));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({chip_en, hf_out, hp_mute, dp_flash, init_pulse, key_ok} == 6'b0,
            "R1 reset state", {chip_en, hf_out, hp_mute, dp_flash, init_pulse, key_ok}, 0);
        rst_n = 1;
        step();

        // R5: hold ignored on-hook and disabled
        hold_key = 1; step(); step();
        chk(!hp_mute && !hf_out && !chip_en, "R5 hold while disabled", hp_mute, 0);

        // R3 + R1: handsfree on-hook enables, second pulse disables
        hf_pulse();
        chk(hf_out && chip_en && !hp_mute, "R3 hf toggle on", hf_out, 1);
        hf_pulse();
        chk(!hf_out && !chip_en, "R3 hf toggle off", chip_en, 0);

        // R2: slow debounce to off-hook
        hook_to(1'b0, 1'b1, DS, "R2 slow debounce off-hook");
        chk(!hf_out && !hp_mute, "R6 talk after off-hook", hf_out, 0);

        // R8/R9/R11: each flash key
        for (int s = 0; s < 4; s++) run_flash(s, 0);
        // R10: re-press during break
        run_flash(0, 1);

        // R11: flash and other key together
        align();
        flash_sel = 2'd2; flash_key = 1; other_key = 1; #1;
        chk(key_ok == 0, "R11 flash wins same cycle", key_ok, 0);
        step();
        chk(dp_flash == 1, "R11 flash still taken", dp_flash, 1);
        for (int i = 0; i < 400; i++) step();
        other_key = 1; #1;
        chk(key_ok == 1, "R11 key accepted after flash", key_ok, 1);
        step();

        // R4/R7: hold and lockout
        hold_key = 1; step();
        chk(hp_mute && hf_out && chip_en, "R4 hold entry", hp_mute, 1);
        other_key = 1; #1;
        chk(key_ok == 0, "R7 key refused on hold", key_ok, 0);
        step();
        align(); flash_key = 1; step(); step();
        chk(dp_flash == 0, "R7 flash refused on hold", dp_flash, 0);
        hold_key = 1; step();
        chk(!hp_mute && !hf_out, "R4 hold exit", hf_out, 0);
        hold_key = 1; step();
        // R3: handsfree edge takes over from hold
        hf_pulse();
        chk(hf_out && !hp_mute, "R3 hf discards hold", hp_mute, 0);

        // R6: hold, on-hook (fast) keeps chip on, off-hook clears
        hold_key = 1; step();
        lock_mode = 1;
        hook_sw = 1;
        for (int i = 0; i < 4 * (DF + 2); i++) step();
        chk(chip_en && hp_mute, "R6 hold survives on-hook", chip_en, 1);
        hook_to(1'b0, 1'b1, 0, "R2 no chip change");
        hook_sw = 0;
        begin
            int n = 0;
            for (int i = 0; i < 200 && hp_mute; i++) begin
                if (cyc % 4 == 0) n++;
                step();
            end
            chk(n == DF, "R2 fast debounce", n, DF);
        end
        chk(!hf_out && !hp_mute && chip_en, "R6 off-hook initializes", hf_out, 0);
        lock_mode = 0;

        // R12: on-hook during a flash
        align(); flash_sel = 2'd0; flash_key = 1; step();
        init_n = 0;
        hook_to(1'b1, 1'b0, DS, "R12 on-hook debounce");
        chk(!dp_flash && !chip_en, "R12 flash cut", dp_flash, 0);
        for (int i = 0; i < 200; i++) step();
        chk(init_n == 0, "R12 no init after abort", init_n, 0);

        // random walk on-hook then off-hook
        m = M_OFF; prev_hf = 1;
        for (int ph = 0; ph < 2; ph++) begin
            onh = (ph == 0);
            if (!onh) begin
                hook_sw = 0;
                for (int i = 0; i < 4 * (DS + 2); i++) step();
                m = M_TALK;
            end
            for (int i = 0; i < 400; i++) begin
                bit exp_ok;
                hf_in_n   = ($urandom % 4) != 0;
                hold_key  = ($urandom % 5) == 0;
                other_key = ($urandom % 2) == 0;
                #1;
                exp_ok = other_key && (m == M_TALK || m == M_HANDS);
                chk(key_ok == exp_ok, "R7 random key gate", key_ok, exp_ok);
                m = next_m(m, prev_hf && !hf_in_n, hold_key, onh);
                prev_hf = hf_in_n;
                step();
                chk(hf_out == (m == M_HANDS || m == M_HOLD), "R3 random hf_out",
                    hf_out, (m == M_HANDS || m == M_HOLD));
                chk(hp_mute == (m == M_HOLD), "R4 random hold", hp_mute, (m == M_HOLD));
                chk(chip_en == (m != M_OFF), "R1 random enable", chip_en, (m != M_OFF));
            end
            hf_in_n = 1; prev_hf = 1; step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule